// File: doc/BRIEF.md
# Register Renamer with Zeroing and Move Elimination

The block maps micro-ops written against 16 architectural registers onto a larger physical register file. It handles a group of up to four micro-ops each cycle. Every source is translated through an alias table. Every destination receives a fresh physical tag from a free pool, and the tag it replaces is handed back with the micro-op so that it can be recycled at retirement. The translation is resolved in order inside the group, so a later micro-op sees the tags that earlier micro-ops in the same group produce.

Two idioms are resolved inside the table and never reach an execution unit. Clearing a register points it at a constant-zero physical register. A register-to-register copy points the destination at the source's physical register. Copies are tracked by a small pool of alias slots. Each slot holds a reference count, so a shared physical register is not recycled while any architectural name or pending retirement still refers to it. When the pool is exhausted, a copy is renamed and issued like any other operation. If the free pool cannot supply every tag the group needs, the whole group is held back.

Top module: `reg_renamer`

## Requirements
- R1: Each lane's source tags come from the alias table after every earlier valid lane of the same group has applied its destination update. After reset, every architectural register maps to tag 0.
- R2: A lane that writes a normal destination takes the lowest-numbered free tag; later lanes take the next lowest. Such a lane has `out_issue`=1.
- R3: `out_pprev` carries the tag the destination mapped to just before this lane, including a mapping made by an earlier lane of the same group.
- R4: A lane with `in_zero`=1 (and a destination) gets `out_pdst`=0 and `out_issue`=0, and it allocates no tag.
- R5: A lane with `in_move`=1 copies from `in_src0`. When its source tag is nonzero and either already held by an alias slot or a slot is free, the lane gets `out_pdst` equal to the source tag and `out_issue`=0, and it allocates nothing.
- R6: A copy whose source maps to tag 0 yields `out_pdst`=0 and `out_issue`=0, and it uses no alias slot.
- R7: A copy whose source tag has no slot while all alias slots are held gets a fresh tag as in R2 and `out_issue`=1.
- R8: When the group needs more tags than are free, `out_ok`=0, and neither the table, the free pool nor the slots change. The same group later renames as if the stalled attempt never happened.
- R9: A tag returned on a retire port becomes allocatable from the next cycle on, not in the cycle it is returned.
- R10: A tag held by an alias slot returns to the free pool only after one retirement per reference. At that point the slot is released and can serve a new copy.
- R11: At reset, tags 1 to NUM_PHYS-1 are free. Retiring tag 0 has no effect.
- R12: A lane with `in_valid`=0 gives `out_pdst`=0, `out_pprev`=0 and `out_issue`=0. A valid lane with `in_dst_en`=0 allocates nothing, gives `out_pdst`=0 and `out_pprev`=0, and has `out_issue`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | GROUP | Lane holds a micro-op |
| in_dst_en | input | GROUP | Lane writes a destination |
| in_zero | input | GROUP | Lane is a register-clearing idiom |
| in_move | input | GROUP | Lane is a register copy from src0 |
| in_src0 | input | GROUP x 4 | First architectural source |
| in_src1 | input | GROUP x 4 | Second architectural source |
| in_dst | input | GROUP x 4 | Architectural destination |
| ret_valid | input | GROUP | Retire port carries a tag to release |
| ret_tag | input | GROUP x PW | Tag released at retirement |
| out_ok | output | 1 | Group renamed this cycle (0 = stalled) |
| out_psrc0 | output | GROUP x PW | Physical tag of first source |
| out_psrc1 | output | GROUP x PW | Physical tag of second source |
| out_pdst | output | GROUP x PW | New physical tag of destination |
| out_pprev | output | GROUP x PW | Replaced mapping of destination |
| out_issue | output | GROUP | Lane must be sent for execution |

## Verification
The bench builds the block with a 16-entry physical file, leaving 15 allocatable tags, while the group width, architectural count and slot count keep their defaults. With this small file, a few groups exhaust the pool, so a stall on a partial shortfall, the same-cycle retire rule and reuse of a tag freed by its last alias all occur within a short directed run. The alias slots also fill after three groups, which makes the pool-exhausted copy path reachable.

// File: rtl/ren_pkg.sv
// Package: shared classification of a renamed lane.
// Assumes: used by the renamer and its helpers only.
package ren_pkg;
    typedef enum logic [1:0] {
        LANE_IDLE  = 2'd0,  // invalid lane
        LANE_ISSUE = 2'd1,  // goes to execution
        LANE_ZERO  = 2'd2,  // resolved to the constant-zero tag
        LANE_ELIM  = 2'd3   // resolved by aliasing an existing tag
    } lane_kind_e;
endpackage

// File: rtl/ren_pick.sv
// Module: finds the lowest-numbered set bits of a free mask, up to PICKS of them.
// Assumes: purely combinational; bit 0 of the mask is never set by the caller.
module ren_pick #(
    parameter int NUM_PHYS = 64,
    parameter int PICKS    = 4,
    localparam int PW = $clog2(NUM_PHYS),
    localparam int NW = $clog2(PICKS + 1)
) (
    input  logic [NUM_PHYS-1:0]      mask,
    output logic [PICKS-1:0][PW-1:0] pick,
    output logic [NW-1:0]            count
);
    logic [NUM_PHYS-1:0] rest;
    logic                found;

    // scan the mask once per pick, removing each tag as it is taken
    always_comb begin
        rest  = mask;
        count = '0;
        found = 1'b0;
        for (int k = 0; k < PICKS; k++) begin
            pick[k] = '0;
            found   = 1'b0;
            for (int t = 0; t < NUM_PHYS; t++) begin
                if (!found && rest[t]) begin
                    found   = 1'b1;
                    pick[k] = PW'(t);
                    rest[t] = 1'b0;
                end
            end
            if (found) count = count + 1'b1;
        end
    end
endmodule

// File: rtl/ren_freelist.sv
// Module: bitmap pool of free physical tags with lowest-first selection.
// Assumes: take_mask only names tags offered on pick; give_mask only names busy tags.
module ren_freelist #(
    parameter int NUM_PHYS = 64,
    parameter int PICKS    = 4,
    localparam int PW = $clog2(NUM_PHYS),
    localparam int NW = $clog2(PICKS + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_PHYS-1:0]      take_mask,
    input  logic [NUM_PHYS-1:0]      give_mask,
    output logic [PICKS-1:0][PW-1:0] pick,
    output logic [NW-1:0]            avail
);
    logic [NUM_PHYS-1:0] free_q;

    // hold the pool; tag 0 is never placed in it
    always_ff @(posedge clk) begin
        if (!rst_n) free_q <= {{(NUM_PHYS-1){1'b1}}, 1'b0};
        else        free_q <= ((free_q & ~take_mask) | give_mask) & ~NUM_PHYS'(1);
    end

    ren_pick #(.NUM_PHYS(NUM_PHYS), .PICKS(PICKS)) u_pick (
        .mask (free_q),
        .pick (pick),
        .count(avail)
    );

    // R2
    take_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_mask & ~free_q) == '0);
    // R9
    no_double_give_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (give_mask & free_q) == '0);
    // R11
    zero_never_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        free_q[0] == 1'b0);
endmodule

// File: rtl/reg_renamer.sv
// Module: renames a group of micro-ops, resolving clear and copy idioms in the table.
// Assumes: tags on ret_tag were produced as out_pprev of renamed lanes, each retired once.
module reg_renamer
    import ren_pkg::*;
#(
    parameter int GROUP     = 4,
    parameter int NUM_ARCH  = 16,
    parameter int NUM_PHYS  = 64,
    parameter int NUM_SLOTS = 4,
    parameter int CNT_W     = 6,
    localparam int AW = $clog2(NUM_ARCH),
    localparam int PW = $clog2(NUM_PHYS),
    localparam int NW = $clog2(GROUP + 1),
    localparam int IW = (GROUP > 1) ? $clog2(GROUP) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [GROUP-1:0]         in_valid,
    input  logic [GROUP-1:0]         in_dst_en,
    input  logic [GROUP-1:0]         in_zero,
    input  logic [GROUP-1:0]         in_move,
    input  logic [GROUP-1:0][AW-1:0] in_src0,
    input  logic [GROUP-1:0][AW-1:0] in_src1,
    input  logic [GROUP-1:0][AW-1:0] in_dst,
    input  logic [GROUP-1:0]         ret_valid,
    input  logic [GROUP-1:0][PW-1:0] ret_tag,
    output logic                     out_ok,
    output logic [GROUP-1:0][PW-1:0] out_psrc0,
    output logic [GROUP-1:0][PW-1:0] out_psrc1,
    output logic [GROUP-1:0][PW-1:0] out_pdst,
    output logic [GROUP-1:0][PW-1:0] out_pprev,
    output logic [GROUP-1:0]         out_issue
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [NUM_ARCH-1:0][PW-1:0]  rat_q, rat_w;
    logic [NUM_SLOTS-1:0]         sv_q, sv_r, sv_w;
    logic [NUM_SLOTS-1:0][PW-1:0] st_q, st_r, st_w;
    logic [NUM_SLOTS-1:0][CNT_W-1:0] sc_q, sc_r, sc_w;
    logic [NUM_PHYS-1:0]          take_mask, give_mask;
    logic [GROUP-1:0][PW-1:0]     pick;
    logic [NW-1:0]                avail, used;
    logic                         short_f, hit, grew;
    lane_kind_e [GROUP-1:0]       kind;

    ren_freelist #(.NUM_PHYS(NUM_PHYS), .PICKS(GROUP)) u_free (
        .clk      (clk),
        .rst_n    (rst_n),
        .take_mask(out_ok ? take_mask : '0),
        .give_mask(give_mask),
        .pick     (pick),
        .avail    (avail)
    );

    // apply retirements to the alias slots and collect tags to release
    always_comb begin
        sv_r = sv_q; st_r = st_q; sc_r = sc_q;
        give_mask = '0;
        hit = 1'b0;
        for (int r = 0; r < GROUP; r++) begin
            if (ret_valid[r] && ret_tag[r] != '0) begin
                hit = 1'b0;
                for (int s = 0; s < NUM_SLOTS; s++) begin
                    if (!hit && sv_r[s] && st_r[s] == ret_tag[r]) begin
                        hit = 1'b1;
                        sc_r[s] = sc_r[s] - 1'b1;
                        if (sc_r[s] == '0) begin
                            sv_r[s] = 1'b0;
                            give_mask[ret_tag[r]] = 1'b1;
                        end
                    end
                end
                if (!hit) give_mask[ret_tag[r]] = 1'b1;
            end
        end
    end

    // rename the group lane by lane against a working copy of the table
    always_comb begin
        rat_w = rat_q; sv_w = sv_r; st_w = st_r; sc_w = sc_r;
        take_mask = '0; used = '0; short_f = 1'b0; grew = 1'b0;
        for (int i = 0; i < GROUP; i++) begin
            out_psrc0[i] = rat_w[in_src0[i]];
            out_psrc1[i] = rat_w[in_src1[i]];
            out_pdst[i]  = '0;
            out_pprev[i] = '0;
            kind[i]      = in_valid[i] ? LANE_ISSUE : LANE_IDLE;
            if (in_valid[i] && in_dst_en[i]) begin
                out_pprev[i] = rat_w[in_dst[i]];
                if (in_zero[i] || (in_move[i] && out_psrc0[i] == '0)) begin
                    kind[i] = LANE_ZERO;
                end else begin
                    grew = 1'b0;
                    if (in_move[i]) begin
                        for (int s = 0; s < NUM_SLOTS; s++) begin
                            if (!grew && sv_w[s] && st_w[s] == out_psrc0[i]) begin
                                grew = 1'b1;
                                sc_w[s] = sc_w[s] + 1'b1;
                            end
                        end
                        for (int s = 0; s < NUM_SLOTS; s++) begin
                            if (!grew && !sv_w[s]) begin
                                grew = 1'b1;
                                sv_w[s] = 1'b1;
                                st_w[s] = out_psrc0[i];
                                sc_w[s] = CNT_W'(2);
                            end
                        end
                    end
                    if (grew) begin
                        kind[i]     = LANE_ELIM;
                        out_pdst[i] = out_psrc0[i];
                    end else if (used < avail) begin
                        out_pdst[i] = pick[used[IW-1:0]];
                        take_mask[pick[used[IW-1:0]]] = 1'b1;
                        used = used + 1'b1;
                    end else begin
                        short_f = 1'b1;
                    end
                end
                rat_w[in_dst[i]] = out_pdst[i];
            end
            out_issue[i] = (kind[i] == LANE_ISSUE);
        end
        out_ok = !short_f;
    end

    // commit the table and slots; a stalled group keeps only retirement effects
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rat_q <= '0;
            sv_q  <= '0;
            st_q  <= '0;
            sc_q  <= '0;
        end else if (out_ok) begin
            rat_q <= rat_w;
            sv_q  <= sv_w;
            st_q  <= st_w;
            sc_q  <= sc_w;
        end else begin
            sv_q  <= sv_r;
            st_q  <= st_r;
            sc_q  <= sc_r;
        end
    end

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_ok |=> rat_q == $past(rat_q));

    generate
        for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot_chk
            // R10
            slot_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
                sv_q[s] |-> (sc_q[s] != '0 && st_q[s] != '0));
            // R10
            no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
                sv_q[s] |-> sc_q[s] != CNT_MAX);
        end
    endgenerate
endmodule

// File: tb/reg_renamer_test.sv
module reg_renamer_test;
    localparam int G = 4;
    localparam int NP = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [G-1:0] in_valid, in_dst_en, in_zero, in_move, ret_valid, out_issue;
    logic [G-1:0][3:0] in_src0, in_src1, in_dst, ret_tag;
    logic [G-1:0][3:0] out_psrc0, out_psrc1, out_pdst, out_pprev;
    logic out_ok;

    reg_renamer #(.GROUP(G), .NUM_ARCH(16), .NUM_PHYS(NP), .NUM_SLOTS(4)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dst_en(in_dst_en),
        .in_zero(in_zero), .in_move(in_move), .in_src0(in_src0), .in_src1(in_src1),
        .in_dst(in_dst), .ret_valid(ret_valid), .ret_tag(ret_tag), .out_ok(out_ok),
        .out_psrc0(out_psrc0), .out_psrc1(out_psrc1), .out_pdst(out_pdst),
        .out_pprev(out_pprev), .out_issue(out_issue)
    );

    typedef struct packed {
        logic [3:0] rq;
        logic v, de, z, m;
        logic [3:0] s0, s1, d, e0, e1, ed, ep;
        logic ei;
    } row_t;

    // four consecutive rows form one group; every group is expected to rename
    localparam int NROWS = 24;
    localparam row_t TAB [NROWS] = '{
        // group 1: allocation from reset, forwarding, copy, clear
        '{2, 1,1,0,0, 2, 3, 1, 0,0,1,0,1},   // R2 first free tag is 1
        '{1, 1,1,0,0, 1, 1, 2, 1,1,2,0,1},   // R1 sees lane 0 result
        '{5, 1,1,0,1, 1, 0, 3, 1,0,1,0,0},   // R5 copy eliminated
        '{4, 1,1,1,0, 4, 4, 4, 0,0,0,0,0},   // R4 clear idiom
        // group 2
        '{5, 1,1,0,1, 2, 0, 5, 2,0,2,0,0},   // R5
        '{6, 1,1,0,1, 0, 0, 6, 0,0,0,0,0},   // R6 copy of zero
        '{5, 1,1,0,1, 1, 0, 7, 1,0,1,0,0},   // R5 joins existing slot
        '{12,0,0,0,0, 0, 0, 0, 0,0,0,0,0},   // R12 idle lane
        // group 3: fills the last two slots
        '{2, 1,1,0,0, 1, 2, 8, 1,2,3,0,1},   // R2
        '{1, 1,1,0,0, 8, 0, 9, 3,0,4,0,1},   // R1
        '{5, 1,1,0,1, 8, 0,10, 3,0,3,0,0},   // R5
        '{5, 1,1,0,1, 9, 0,11, 4,0,4,0,0},   // R5
        // group 4: slots full
        '{2, 1,1,0,0, 1, 1,13, 1,1,5,0,1},   // R2
        '{7, 1,1,0,1,13, 0,12, 5,0,6,0,1},   // R7 copy allocates
        '{5, 1,1,0,1, 1, 0,14, 1,0,1,0,0},   // R5 held tag still aliases
        '{3, 1,1,1,0, 1, 1, 1, 1,1,0,1,0},   // R3 replaced mapping
        // group 5: chain on one destination
        '{2, 1,1,0,0,15,14,15, 0,1,7,0,1},   // R2
        '{3, 1,1,0,0,15,14,15, 7,1,8,7,1},   // R3 in-group previous
        '{3, 1,1,0,0,15,14,15, 8,1,9,8,1},   // R3
        '{3, 1,1,0,0,15,14,15, 9,1,10,9,1},  // R3
        // group 6
        '{2, 1,1,0,0,15,14,15,10,1,11,10,1}, // R2
        '{12,1,0,0,0,15,14, 0,11,1,0,0,1},   // R12 no destination
        '{2, 1,1,0,0,15,14,15,11,1,12,11,1}, // R2
        '{3, 1,1,0,0,15,14,15,12,1,13,12,1}  // R3
    };

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic clear_in();
        in_valid = '0; in_dst_en = '0; in_zero = '0; in_move = '0;
        in_src0 = '0; in_src1 = '0; in_dst = '0; ret_valid = '0; ret_tag = '0;
    endtask

    // drive lane 0 (optionally with a retirement) and sample before the edge
    task automatic lane0(input logic v, de, z, m, input logic [3:0] s0, s1, d,
                         input logic rv, input logic [3:0] rt);
        @(negedge clk);
        clear_in();
        in_valid[0] = v; in_dst_en[0] = de; in_zero[0] = z; in_move[0] = m;
        in_src0[0] = s0; in_src1[0] = s1; in_dst[0] = d;
        ret_valid[0] = rv; ret_tag[0] = rt;
        #1;
    endtask

    initial begin
        clear_in();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R11 reset state: no group pending, nothing renamed
        #1;
        check(out_ok == 1'b1, "R11", "ok after reset", out_ok, 1);
        check(out_issue == '0, "R12", "issue idle", out_issue, 0);

        // table walk
        for (int g = 0; g < NROWS / G; g++) begin
            @(negedge clk);
            clear_in();
            for (int l = 0; l < G; l++) begin
                in_valid[l] = TAB[g*G+l].v;  in_dst_en[l] = TAB[g*G+l].de;
                in_zero[l]  = TAB[g*G+l].z;  in_move[l]   = TAB[g*G+l].m;
                in_src0[l]  = TAB[g*G+l].s0; in_src1[l]   = TAB[g*G+l].s1;
                in_dst[l]   = TAB[g*G+l].d;
            end
            #1;
            check(out_ok == 1'b1, "R8", "group ok", out_ok, 1);
            for (int l = 0; l < G; l++) begin
                row_t r;
                string rq;
                r = TAB[g*G+l];
                rq = $sformatf("R%0d", r.rq);
                check(out_psrc0[l] == r.e0, rq, "psrc0", out_psrc0[l], r.e0);
                check(out_psrc1[l] == r.e1, rq, "psrc1", out_psrc1[l], r.e1);
                check(out_pdst[l] == r.ed, rq, "pdst", out_pdst[l], r.ed);
                check(out_pprev[l] == r.ep, rq, "pprev", out_pprev[l], r.ep);
                check(out_issue[l] == r.ei, rq, "issue", out_issue[l], r.ei);
            end
        end

        // R8 three allocations with two free tags: whole group held
        @(negedge clk);
        clear_in();
        for (int l = 0; l < 3; l++) begin
            in_valid[l] = 1; in_dst_en[l] = 1; in_src0[l] = 15; in_src1[l] = 14; in_dst[l] = 15;
        end
        #1;
        check(out_ok == 1'b0, "R8", "stall on shortfall", out_ok, 0);

        // R8 nothing taken or remapped by the stalled group
        lane0(1,1,0,0, 15,14,15, 0,0);
        check(out_ok == 1'b1, "R8", "ok after stall", out_ok, 1);
        check(out_pdst[0] == 14, "R8", "pdst after stall", out_pdst[0], 14);
        check(out_pprev[0] == 13, "R8", "pprev after stall", out_pprev[0], 13);
        lane0(1,1,0,0, 15,14,15, 0,0);
        check(out_pdst[0] == 15, "R2", "last tag", out_pdst[0], 15);

        // R11 retiring tag 0 frees nothing
        lane0(0,0,0,0, 0,0,0, 1,0);
        lane0(1,1,0,0, 15,14,15, 0,0);
        check(out_ok == 1'b0, "R11", "tag 0 not freed", out_ok, 0);

        // R9 retired tag not usable in the same cycle
        lane0(1,1,0,0, 15,14,15, 1,7);
        check(out_ok == 1'b0, "R9", "same-cycle reuse", out_ok, 0);
        lane0(1,1,0,0, 15,14,15, 0,0);
        check(out_ok == 1'b1 && out_pdst[0] == 7, "R9", "reuse next cycle", out_pdst[0], 7);

        // R10 aliased tag 3 (r8, r10) released after both references retire
        lane0(1,1,1,0, 8,8,8, 0,0);
        check(out_pprev[0] == 3 && out_issue[0] == 0, "R4", "clear r8", out_pprev[0], 3);
        lane0(1,1,1,0, 10,10,10, 0,0);
        check(out_pprev[0] == 3, "R3", "clear r10 prev", out_pprev[0], 3);
        lane0(0,0,0,0, 0,0,0, 1,3);
        lane0(1,1,0,0, 15,14,15, 0,0);
        check(out_ok == 1'b0, "R10", "held after one retire", out_ok, 0);
        lane0(0,0,0,0, 0,0,0, 1,3);
        lane0(1,1,0,0, 15,14,15, 0,0);
        check(out_ok == 1'b1 && out_pdst[0] == 3, "R10", "freed after last retire", out_pdst[0], 3);
        check(out_pprev[0] == 7, "R3", "prev of r15", out_pprev[0], 7);

        // R10 released slot serves a new copy of tag 3
        lane0(1,1,0,1, 15,0,13, 0,0);
        check(out_pdst[0] == 3 && out_issue[0] == 0, "R10", "slot reused", out_pdst[0], 3);
        check(out_pprev[0] == 5, "R3", "prev of r13", out_pprev[0], 5);

        @(negedge clk);
        clear_in();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule